// File: doc/BRIEF.md
# Frame List Scheduler with Control/Bulk Service Ratio

This block decides, frame by frame, which descriptor list a host controller works on. A start-of-frame event begins a new frame. The periodic list is served first. When it is finished, or when it is cut short by an isochronous descriptor while isochronous service is off, the rest of the frame goes to the control and bulk lists. Those two lists alternate under a programmable ratio. An end-of-frame event returns the block to idle.

The four list enables are copied into shadow registers at start-of-frame, so a change made during a frame takes effect in the next one. The control/bulk ratio counter counts nonempty control descriptors only. It survives frame boundaries and is cleared only by hardware reset or by serving a bulk descriptor. Fetching descriptors, running transfers and accessing memory are handled outside this block, which reports its choice on `listSel`.

Top module: `frame_list_sched`

## Requirements
- R1: During and after reset `listSel` is idle (encoding 00), the ratio counter is zero and all enable shadows are clear.
- R2: A `sofPulse` with `enPeriodic` high moves `listSel` to periodic (01) on the next cycle. `sofPulse` takes priority over every other event in the same cycle.
- R3: In the periodic state, `listEnd` hands the frame to the nonperiodic choice: control (10), bulk (11) or idle.
- R4: In the periodic state, a `descFetched` with `descIsIso` high leaves periodic for the nonperiodic choice when the isochronous shadow is clear. When the shadow is set, periodic service continues.
- R5: The enables are sampled only at `sofPulse`. Changing `enPeriodic`, `enIso`, `enControl` or `enBulk` mid-frame does not change `listSel` until the next frame.
- R6: When both nonperiodic lists are available, bulk is chosen once the count of nonempty control descriptors exceeds `svcRatio`: 00 gives 1:1, 01 gives 2:1, 10 gives 3:1 and 11 gives 4:1. A completed bulk descriptor clears the count.
- R7: A control descriptor finished with `descNonEmpty` low does not advance the count.
- R8: The count is not cleared at start-of-frame or end-of-frame. It carries over into the next frame.
- R9: If one nonperiodic list is disabled for the frame, or has reported `listEnd`, the other is served without regard to the ratio. If neither is available, `listSel` stays idle until the frame ends.
- R10: `eofPulse` makes `listSel` idle on the next cycle. In the idle state, descriptor events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sofPulse | input | 1 | Start of frame |
| eofPulse | input | 1 | End of frame |
| enPeriodic | input | 1 | Periodic list enable |
| enIso | input | 1 | Isochronous descriptor enable |
| enControl | input | 1 | Control list enable |
| enBulk | input | 1 | Bulk list enable |
| svcRatio | input | RATIO_W | Control-per-bulk ratio minus one |
| descFetched | input | 1 | A descriptor header has been reached |
| descIsIso | input | 1 | Format of the fetched descriptor is isochronous |
| descDone | input | 1 | Current descriptor finished |
| descNonEmpty | input | 1 | The finished descriptor carried work |
| listEnd | input | 1 | Current list has no further descriptors |
| listSel | output | 2 | 00 idle, 01 periodic, 10 control, 11 bulk |

## Verification
The bench builds the block with the default `RATIO_W` of 2, which allows all four ratio codes. The bench uses ratios of 1:1, 2:1 and 4:1. The 4:1 case drives the counter up to its saturation value of four. With one list exhausted, further nonempty control descriptors leave the counter saturated. Three consecutive frames show the count carrying across a frame boundary, and a bench-side change to the enables taking effect only at the following start-of-frame.

// File: rtl/fls_pkg.sv
package fls_pkg;
  typedef enum logic [1:0] {
    LIST_IDLE     = 2'd0,
    LIST_PERIODIC = 2'd1,
    LIST_CONTROL  = 2'd2,
    LIST_BULK     = 2'd3
  } listSel_e;

  localparam int NP_LISTS = 2;
  localparam int NP_CTRL  = 0;
  localparam int NP_BULK  = 1;

  typedef struct packed {
    logic                latchShadow;
    logic                ctrlCount;
    logic                ratioClear;
    logic [NP_LISTS-1:0] exhaust;
  } dpStrobe_t;
endpackage

// File: rtl/fls_datapath.sv
module fls_datapath
  import fls_pkg::*;
#(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  logic               enPeriodic,
  input  logic               enIso,
  input  logic               enControl,
  input  logic               enBulk,
  input  logic [RATIO_W-1:0] svcRatio,
  output logic               periodicGo,
  output logic               isoAllowed,
  output logic               ctrlAvailNext,
  output logic               bulkAvailNext,
  output logic               preferBulkNext,
  output logic               ctrlAvailNow,
  output logic               bulkAvailNow
);
  localparam int CNT_W = RATIO_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(1) << RATIO_W;

  logic isoSh, isoShNext;
  logic [NP_LISTS-1:0] npSh, npShNext, rawNp;
  logic [NP_LISTS-1:0] exhNow, exhNext;
  logic [CNT_W-1:0] cnt, cntNext;

  assign rawNp[NP_CTRL] = enControl;
  assign rawNp[NP_BULK] = enBulk;

  assign isoShNext = strobe.latchShadow ? enIso : isoSh;
  assign periodicGo = strobe.latchShadow & enPeriodic;

  genvar gi;
  generate
    for (gi = 0; gi < NP_LISTS; gi++) begin : g_np
      always_comb begin
        npShNext[gi] = strobe.latchShadow ? rawNp[gi] : npSh[gi];
        if (strobe.latchShadow)     exhNext[gi] = 1'b0;
        else if (strobe.exhaust[gi]) exhNext[gi] = 1'b1;
        else                         exhNext[gi] = exhNow[gi];
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          npSh[gi]   <= 1'b0;
          exhNow[gi] <= 1'b0;
        end else begin
          npSh[gi]   <= npShNext[gi];
          exhNow[gi] <= exhNext[gi];
        end
      end
    end
  endgenerate

  always_comb begin
    cntNext = cnt;
    if (strobe.ratioClear)
      cntNext = '0;
    else if (strobe.ctrlCount && cnt != CNT_MAX)
      cntNext = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isoSh <= 1'b0;
      cnt   <= '0;
    end else begin
      isoSh <= isoShNext;
      cnt   <= cntNext;
    end
  end

  assign isoAllowed     = isoSh;
  assign ctrlAvailNext  = npShNext[NP_CTRL] & ~exhNext[NP_CTRL];
  assign bulkAvailNext  = npShNext[NP_BULK] & ~exhNext[NP_BULK];
  assign preferBulkNext = cntNext > {1'b0, svcRatio};
  assign ctrlAvailNow   = npSh[NP_CTRL] & ~exhNow[NP_CTRL];
  assign bulkAvailNow   = npSh[NP_BULK] & ~exhNow[NP_BULK];

  // R8: the count moves only on a control or bulk completion strobe
  a_r8_count_held: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.ctrlCount || strobe.ratioClear) |=> $stable(cnt));
  // R7: the count never exceeds its saturation value
  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_MAX);
  // R6: a served bulk descriptor clears the count
  a_r6_bulk_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ratioClear |=> cnt == '0);
  // R5: a shadow changes only at a latch strobe
  a_r5_shadow_frame: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchShadow |=> $stable(npSh) && $stable(isoSh));
endmodule

// File: rtl/fls_control.sv
module fls_control
  import fls_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sofPulse,
  input  logic      eofPulse,
  input  logic      descFetched,
  input  logic      descIsIso,
  input  logic      descDone,
  input  logic      descNonEmpty,
  input  logic      listEnd,
  input  logic      periodicGo,
  input  logic      isoAllowed,
  input  logic      ctrlAvailNext,
  input  logic      bulkAvailNext,
  input  logic      preferBulkNext,
  input  logic      ctrlAvailNow,
  input  logic      bulkAvailNow,
  output dpStrobe_t strobe,
  output listSel_e  cur
);
  listSel_e nxt, npChoice;
  logic leavePeriodic;

  // Strobes depend only on state and inputs, never on the next-state choice
  always_comb begin
    strobe = '0;
    if (sofPulse) begin
      strobe.latchShadow = 1'b1;
    end else if (!eofPulse) begin
      unique case (cur)
        LIST_CONTROL: begin
          if (listEnd)       strobe.exhaust[NP_CTRL] = 1'b1;
          else if (descDone) strobe.ctrlCount = descNonEmpty;
        end
        LIST_BULK: begin
          if (listEnd)       strobe.exhaust[NP_BULK] = 1'b1;
          else if (descDone) strobe.ratioClear = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (ctrlAvailNext && bulkAvailNext)
      npChoice = preferBulkNext ? LIST_BULK : LIST_CONTROL;
    else if (ctrlAvailNext)
      npChoice = LIST_CONTROL;
    else if (bulkAvailNext)
      npChoice = LIST_BULK;
    else
      npChoice = LIST_IDLE;
  end

  assign leavePeriodic = listEnd || (descFetched && descIsIso && !isoAllowed);

  always_comb begin
    nxt = cur;
    if (sofPulse) begin
      nxt = periodicGo ? LIST_PERIODIC : npChoice;
    end else if (eofPulse) begin
      nxt = LIST_IDLE;
    end else begin
      unique case (cur)
        LIST_PERIODIC: if (leavePeriodic) nxt = npChoice;
        LIST_CONTROL, LIST_BULK: if (listEnd || descDone) nxt = npChoice;
        default: nxt = cur;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) cur <= LIST_IDLE;
    else       cur <= nxt;
  end

  // R10: end of frame without a new start returns to idle
  a_r10_eof_idle: assert property (@(posedge clk) disable iff (!rstN)
    (eofPulse && !sofPulse) |=> cur == LIST_IDLE);
  // R2: start of frame with periodic enabled enters periodic
  a_r2_sof_periodic: assert property (@(posedge clk) disable iff (!rstN)
    periodicGo |=> cur == LIST_PERIODIC);
  // R5: periodic is only ever entered at start of frame
  a_r5_periodic_at_sof: assert property (@(posedge clk) disable iff (!rstN)
    (cur != LIST_PERIODIC && !sofPulse) |=> cur != LIST_PERIODIC);
  // R9: a nonperiodic list is selected only while it is available
  a_r9_ctrl_avail: assert property (@(posedge clk) disable iff (!rstN)
    cur == LIST_CONTROL |-> ctrlAvailNow);
  a_r9_bulk_avail: assert property (@(posedge clk) disable iff (!rstN)
    cur == LIST_BULK |-> bulkAvailNow);
endmodule

// File: rtl/frame_list_sched.sv
module frame_list_sched
  import fls_pkg::*;
#(
  parameter int RATIO_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sofPulse,
  input  logic               eofPulse,
  input  logic               enPeriodic,
  input  logic               enIso,
  input  logic               enControl,
  input  logic               enBulk,
  input  logic [RATIO_W-1:0] svcRatio,
  input  logic               descFetched,
  input  logic               descIsIso,
  input  logic               descDone,
  input  logic               descNonEmpty,
  input  logic               listEnd,
  output logic [1:0]         listSel
);
  dpStrobe_t strobe;
  listSel_e  cur;
  logic periodicGo, isoAllowed, ctrlAvailNext, bulkAvailNext;
  logic preferBulkNext, ctrlAvailNow, bulkAvailNow;

  fls_datapath #(.RATIO_W(RATIO_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .enPeriodic(enPeriodic), .enIso(enIso), .enControl(enControl), .enBulk(enBulk),
    .svcRatio(svcRatio), .periodicGo(periodicGo), .isoAllowed(isoAllowed),
    .ctrlAvailNext(ctrlAvailNext), .bulkAvailNext(bulkAvailNext),
    .preferBulkNext(preferBulkNext), .ctrlAvailNow(ctrlAvailNow),
    .bulkAvailNow(bulkAvailNow)
  );

  fls_control i_ctl (
    .clk(clk), .rstN(rstN), .sofPulse(sofPulse), .eofPulse(eofPulse),
    .descFetched(descFetched), .descIsIso(descIsIso), .descDone(descDone),
    .descNonEmpty(descNonEmpty), .listEnd(listEnd), .periodicGo(periodicGo),
    .isoAllowed(isoAllowed), .ctrlAvailNext(ctrlAvailNext),
    .bulkAvailNext(bulkAvailNext), .preferBulkNext(preferBulkNext),
    .ctrlAvailNow(ctrlAvailNow), .bulkAvailNow(bulkAvailNow),
    .strobe(strobe), .cur(cur)
  );

  assign listSel = cur;
endmodule

// File: tb/test_frame_list_sched.sv
module test_frame_list_sched;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sofPulse = 0, eofPulse = 0, descFetched = 0, descIsIso = 0;
  logic descDone = 0, descNonEmpty = 0, listEnd = 0;
  logic enPeriodic = 1, enIso = 1, enControl = 1, enBulk = 1;
  logic [1:0] svcRatio = 2'b01;
  logic [1:0] listSel;

  localparam logic [1:0] IDL = 2'd0, PER = 2'd1, CTL = 2'd2, BLK = 2'd3;

  typedef struct { logic [1:0] exp; string tag; } item_t;
  item_t sb[$];
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  frame_list_sched i_frame_list_sched (
    .clk(clk), .rstN(rstN), .sofPulse(sofPulse), .eofPulse(eofPulse),
    .enPeriodic(enPeriodic), .enIso(enIso), .enControl(enControl), .enBulk(enBulk),
    .svcRatio(svcRatio), .descFetched(descFetched), .descIsIso(descIsIso),
    .descDone(descDone), .descNonEmpty(descNonEmpty), .listEnd(listEnd),
    .listSel(listSel)
  );

  // monitor: pops one expected item per cycle, compares on the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      nChecks++;
      if (listSel !== it.exp) begin
        nFails++;
        $display("FAIL %s: listSel=%0d expected=%0d", it.tag, listSel, it.exp);
      end
    end
  end

  task automatic step(input logic s, e, f, i, d, n, l,
                      input logic [1:0] exp, input string tag);
    @(negedge clk);
    sofPulse = s; eofPulse = e; descFetched = f; descIsIso = i;
    descDone = d; descNonEmpty = n; listEnd = l;
    @(posedge clk);
    #1;
    sb.push_back('{exp, tag});
  endtask

  task automatic sof(input logic [1:0] exp, input string tag);
    step(1,0,0,0,0,0,0, exp, tag);
  endtask
  task automatic eof(input logic [1:0] exp, input string tag);
    step(0,1,0,0,0,0,0, exp, tag);
  endtask
  task automatic done(input logic n, input logic [1:0] exp, input string tag);
    step(0,0,0,0,1,n,0, exp, tag);
  endtask
  task automatic lend(input logic [1:0] exp, input string tag);
    step(0,0,0,0,0,0,1, exp, tag);
  endtask
  task automatic fetch(input logic iso, input logic [1:0] exp, input string tag);
    step(0,0,1,iso,0,0,0, exp, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    nChecks++;
    if (listSel !== IDL) begin
      nFails++;
      $display("FAIL R1 reset: listSel=%0d expected=%0d", listSel, IDL);
    end
    @(negedge clk) rstN = 1'b1;

    // frame 1, ratio 2:1
    sof(PER, "R2 sof enters periodic");
    fetch(1, PER, "R4 iso enabled keeps periodic");
    lend(CTL, "R3 periodic end to control");
    done(1, CTL, "R6 first nonempty control");
    done(0, CTL, "R7 empty control not counted");
    done(1, BLK, "R6 second nonempty control gives bulk");
    done(0, CTL, "R6 bulk done clears count");
    done(1, CTL, "R6 count one");
    eof(IDL, "R10 eof idles");
    done(1, IDL, "R10 events ignored in idle");

    // frame 2: iso off, count carried at 1
    enIso = 0;
    sof(PER, "R2 sof periodic frame2");
    fetch(0, PER, "R4 non-iso descriptor stays periodic");
    fetch(1, CTL, "R4 iso descriptor truncates periodic");
    done(1, BLK, "R8 count carried across frames");
    enControl = 0;
    done(0, CTL, "R5 control disable waits for next frame");
    done(1, CTL, "R5 control still served");
    eof(IDL, "R10 eof frame2");

    // frame 3: periodic and control off
    enPeriodic = 0; enIso = 1;
    sof(BLK, "R9 only bulk available");
    done(0, BLK, "R9 bulk without ratio");
    lend(IDL, "R9 both unavailable idle");
    done(1, IDL, "R9 idle until eof");
    eof(IDL, "R10 eof frame3");

    // frame 4: ratio 1:1, periodic dropped mid-frame
    enPeriodic = 1; enControl = 1; svcRatio = 2'b00;
    sof(PER, "R2 sof frame4");
    enPeriodic = 0;
    lend(CTL, "R6 ratio 1:1 count zero");
    lend(BLK, "R9 control exhausted bulk");
    done(0, BLK, "R9 bulk repeats");
    eof(IDL, "R10 eof frame4");

    // frame 5: periodic disable now in effect, then 4:1
    sof(CTL, "R5 periodic disable applied");
    done(1, BLK, "R6 ratio 1:1");
    svcRatio = 2'b11;
    done(0, CTL, "R6 bulk clears");
    for (int k = 0; k < 3; k++) done(1, CTL, "R6 ratio 4:1 control run");
    done(1, BLK, "R6 ratio 4:1 fourth gives bulk");
    lend(CTL, "R9 bulk exhausted control");
    done(1, CTL, "R7 saturated count control");
    eof(IDL, "R10 eof frame5");

    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule